// File: doc/BRIEF.md
# RF Attenuation Pad Controller

This block switches a fixed attenuation pad into the RF front end when the receiver saturates and removes it again once the signal allows it. It sits beside a receive AGC loop. It owns the attenuation accumulator that the loop adjusts through a signed delta. When the pad is switched in, the block reloads that accumulator with the release threshold and sends a one-cycle pulse that tells the loop to leave lock and settle again.

Three states hold the pad position. `PAD_OFF` is high gain with the pad out. `PAD_SEEK` has the pad in while the AGC is unlocked, and here the threshold is watched. `PAD_HOLD` has the pad in while the AGC is locked on a packet, and here the pad is frozen. The transitions are:
- *engage*: `PAD_OFF` to `PAD_SEEK`.
- *re-engage*: `PAD_SEEK` to `PAD_SEEK`.
- *lock*: `PAD_SEEK` to `PAD_HOLD`.
- *unlock*: `PAD_HOLD` to `PAD_SEEK`.
- *threshold release*: `PAD_SEEK` to `PAD_OFF`.
- *receive-off release*: any state to `PAD_OFF`.

Each transition takes effect at the clock edge after its inputs are sampled. The pad size and the threshold are inputs taken from configuration registers, both in 0.5 dB steps. The suggested defaults are 60 (30 dB) for the pad size and 48 (24 dB) for the threshold.

Top module: `rfpad_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `gain_hi`=1, `acc_val`=0, `drop_lock`=0 and `pad_db`=0.
- R2: In `PAD_OFF` with `rx_en`=1, `agc_locked`=0 and `sat_det`=1, the pad engages at the next edge: `gain_hi`=0 and `drop_lock`=1 in the following cycle.
- R3: An engage or re-engage loads `acc_val` with `thr_cfg`, and the delta of that cycle is discarded.
- R4: While `agc_locked`=1 the `sat_det` input has no effect: a pad that is out stays out and no preload or pulse occurs.
- R5: In `PAD_SEEK` with `sat_det`=0 and `agc_locked`=0, the pad is released at the next edge when `acc_val` < `thr_cfg`. When `acc_val` equals `thr_cfg` the pad is not released.
- R6: In `PAD_HOLD` the pad stays in regardless of `acc_val`, `thr_cfg` and `sat_det`.
- R7: In `PAD_HOLD`, `agc_locked`=0 moves the block to `PAD_SEEK`, where the threshold release works again.
- R8: `rx_en`=0 sends the block to `PAD_OFF` at the next edge from any state. No engage, preload or pulse happens in that cycle.
- R9: In `PAD_SEEK`, an engage condition (`sat_det`=1, unlocked) wins over a threshold release in the same cycle. The pad stays in, the accumulator is reloaded and a pulse is sent.
- R10: `drop_lock` is high for exactly one cycle per engage event and is low in every other cycle.
- R11: `pad_db` equals `pad_cfg` while the pad is in and 0 while it is out.
- R12: Each cycle without a preload, `acc_val` adds the two's-complement 9-bit `acc_delta`. The result saturates at 0 and at 255 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low forces the pad out |
| agc_locked | input | 1 | AGC loop is locked on a packet |
| sat_det | input | 1 | Front end near saturation |
| acc_delta | input | 9 | Signed accumulator step from the AGC loop (0.5 dB units) |
| pad_cfg | input | 8 | Pad attenuation setting (0.5 dB units) |
| thr_cfg | input | 8 | Release threshold and preload value (0.5 dB units) |
| gain_hi | output | 1 | 1 = high gain (pad out), 0 = low gain (pad in) |
| acc_val | output | 8 | Attenuation accumulator |
| pad_db | output | 8 | Attenuation currently applied by the pad |
| drop_lock | output | 1 | One-cycle request to the AGC loop to leave lock |

## Verification
The bench targets same-cycle conflicts:
- Saturation together with a below-threshold accumulator. A wrong priority would drop the pad while the front end is still saturated.
- `rx_en` falling together with saturation. A wrong priority would engage the pad or preload the accumulator.
- The accumulator exactly at the threshold. An off-by-one compare would release the pad one step early.

It also checks the preload against a non-zero delta, which shows whether the preload really overrides the step. It drives the accumulator into both saturation rails, where a wrapping adder would jump to the far end of the range. Finally it confirms that a locked packet keeps the pad frozen through saturation and low accumulator values.

// File: rtl/rfpad_pkg.sv
package rfpad_pkg;

    localparam int unsigned ACC_W_DEF = 8;
    localparam int unsigned PAD_DEF_HALF_DB = 60;
    localparam int unsigned THR_DEF_HALF_DB = 48;

    typedef enum logic [1:0] {
        PAD_OFF  = 2'd0,
        PAD_SEEK = 2'd1,
        PAD_HOLD = 2'd2
    } pad_state_e;

endpackage

// File: rtl/rfpad_acc.sv
module rfpad_acc #(
    parameter int unsigned ACC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    preload,
    input  logic [ACC_W-1:0]        preload_val,
    input  logic signed [ACC_W:0]   delta,
    output logic [ACC_W-1:0]        acc
);

    localparam int unsigned SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] ACC_MAX = SUM_W'((1 << ACC_W) - 1);

    logic signed [SUM_W-1:0] sum_s;
    logic [ACC_W-1:0]        sat_val;

    always_comb begin
        sum_s = $signed({2'b00, acc}) + SUM_W'(delta);
        if (sum_s < 0) begin
            sat_val = '0;
        end else if (sum_s > ACC_MAX) begin
            sat_val = '1;
        end else begin
            sat_val = sum_s[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (preload) begin
            acc <= preload_val;
        end else begin
            acc <= sat_val;
        end
    end

endmodule

// File: rtl/rfpad_fsm.sv
module rfpad_fsm
    import rfpad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic locked,
    input  logic sat,
    input  logic below,
    output logic engage,
    output logic pad_on,
    output logic drop_lock
);

    pad_state_e cur_q, nxt;

    // Next-state decision; receive-off overrides everything.
    always_comb begin
        nxt    = cur_q;
        engage = 1'b0;
        unique case (cur_q)
            PAD_OFF: begin
                if (!locked && sat) begin
                    nxt    = PAD_SEEK;
                    engage = 1'b1;
                end
            end
            PAD_SEEK: begin
                if (locked) begin
                    nxt = PAD_HOLD;
                end else if (sat) begin
                    nxt    = PAD_SEEK;
                    engage = 1'b1;
                end else if (below) begin
                    nxt = PAD_OFF;
                end
            end
            PAD_HOLD: begin
                if (!locked) begin
                    nxt = PAD_SEEK;
                end
            end
            default: nxt = PAD_OFF;
        endcase
        if (!rx_en) begin
            nxt    = PAD_OFF;
            engage = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= PAD_OFF;
        end else begin
            cur_q <= nxt;
        end
    end

    // Output register and decode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_lock <= 1'b0;
        end else begin
            drop_lock <= engage;
        end
    end

    always_comb begin
        pad_on = (cur_q != PAD_OFF);
    end

endmodule

// File: rtl/rfpad_ctrl.sv
module rfpad_ctrl
    import rfpad_pkg::*;
#(
    parameter int unsigned ACC_W = ACC_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_en,
    input  logic                  agc_locked,
    input  logic                  sat_det,
    input  logic signed [ACC_W:0] acc_delta,
    input  logic [ACC_W-1:0]      pad_cfg,
    input  logic [ACC_W-1:0]      thr_cfg,
    output logic                  gain_hi,
    output logic [ACC_W-1:0]      acc_val,
    output logic [ACC_W-1:0]      pad_db,
    output logic                  drop_lock
);

    logic engage;
    logic pad_on;
    logic below;

    assign below = (acc_val < thr_cfg);

    rfpad_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .locked    (agc_locked),
        .sat       (sat_det),
        .below     (below),
        .engage    (engage),
        .pad_on    (pad_on),
        .drop_lock (drop_lock)
    );

    rfpad_acc #(.ACC_W(ACC_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload     (engage),
        .preload_val (thr_cfg),
        .delta       (acc_delta),
        .acc         (acc_val)
    );

    assign gain_hi = !pad_on;
    assign pad_db  = pad_on ? pad_cfg : '0;

endmodule

// File: rtl/rfpad_ctrl_chk.sv
module rfpad_ctrl_chk #(
    parameter int unsigned ACC_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rx_en,
    input logic                  agc_locked,
    input logic                  sat_det,
    input logic signed [ACC_W:0] acc_delta,
    input logic [ACC_W-1:0]      pad_cfg,
    input logic [ACC_W-1:0]      thr_cfg,
    input logic                  gain_hi,
    input logic [ACC_W-1:0]      acc_val,
    input logic [ACC_W-1:0]      pad_db,
    input logic                  drop_lock
);

    a_r2_engage: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !agc_locked && sat_det && gain_hi) |=> (!gain_hi && drop_lock));

    a_r3_preload: assert property (@(posedge clk) disable iff (!rst_n)
        drop_lock |-> (acc_val == $past(thr_cfg)));

    a_r4_lock_ignores_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && agc_locked && gain_hi) |=> (gain_hi && !drop_lock));

    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && agc_locked && !gain_hi) |=> !gain_hi);

    a_r8_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (gain_hi && !drop_lock));

    a_r10_pulse_pad_on: assert property (@(posedge clk) disable iff (!rst_n)
        drop_lock |-> !gain_hi);

    a_r11_pad_db_off: assert property (@(posedge clk) disable iff (!rst_n)
        gain_hi |-> (pad_db == '0));

    a_r12_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!drop_lock && ($past(acc_delta) < 0)) |-> (acc_val <= $past(acc_val)));

    a_r12_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!drop_lock && ($past(acc_delta) > 0)) |-> (acc_val >= $past(acc_val)));

endmodule

bind rfpad_ctrl rfpad_ctrl_chk #(.ACC_W(ACC_W)) chk_i (.*);

// File: tb/rfpad_ctrl_tb_top.sv
`timescale 1ns/1ps
module rfpad_ctrl_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_en = 1'b0;
    logic              agc_locked = 1'b0;
    logic              sat_det = 1'b0;
    logic signed [8:0] acc_delta = '0;
    logic [7:0]        pad_cfg = 8'd60;
    logic [7:0]        thr_cfg = 8'd48;
    logic              gain_hi;
    logic [7:0]        acc_val;
    logic [7:0]        pad_db;
    logic              drop_lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rfpad_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .agc_locked (agc_locked),
        .sat_det    (sat_det),
        .acc_delta  (acc_delta),
        .pad_cfg    (pad_cfg),
        .thr_cfg    (thr_cfg),
        .gain_hi    (gain_hi),
        .acc_val    (acc_val),
        .pad_db     (pad_db),
        .drop_lock  (drop_lock)
    );

    typedef struct packed {
        logic [7:0]        tag;
        logic              rx;
        logic              lk;
        logic              st;
        logic signed [8:0] dl;
        logic [7:0]        thr;
        logic              eg;
        logic [7:0]        ea;
        logic              ed;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{8'd12, 1'b1, 1'b0, 1'b0,  9'sd10,  8'd48, 1'b1, 8'd10,  1'b0}, // R12 add
        '{8'd4,  1'b1, 1'b1, 1'b1,  9'sd5,   8'd48, 1'b1, 8'd15,  1'b0}, // R4 locked, sat ignored
        '{8'd2,  1'b1, 1'b0, 1'b1,  9'sd5,   8'd48, 1'b0, 8'd48,  1'b1}, // R2 engage, R3 preload beats delta
        '{8'd5,  1'b1, 1'b0, 1'b0,  9'sd4,   8'd48, 1'b0, 8'd52,  1'b0}, // R5 equal: no release; R10 pulse ended
        '{8'd6,  1'b1, 1'b1, 1'b0, -9'sd20,  8'd48, 1'b0, 8'd32,  1'b0}, // R6 lock -> hold
        '{8'd6,  1'b1, 1'b1, 1'b1, -9'sd10,  8'd48, 1'b0, 8'd22,  1'b0}, // R6 below + sat while held
        '{8'd7,  1'b1, 1'b0, 1'b0,  9'sd0,   8'd48, 1'b0, 8'd22,  1'b0}, // R7 unlock -> seek
        '{8'd9,  1'b1, 1'b0, 1'b1,  9'sd0,   8'd48, 1'b0, 8'd48,  1'b1}, // R9 engage beats release
        '{8'd5,  1'b1, 1'b0, 1'b0, -9'sd1,   8'd48, 1'b0, 8'd47,  1'b0}, // R5 at threshold: stays
        '{8'd5,  1'b1, 1'b0, 1'b0,  9'sd0,   8'd48, 1'b1, 8'd47,  1'b0}, // R5 below: release
        '{8'd2,  1'b1, 1'b0, 1'b1,  9'sd0,   8'd48, 1'b0, 8'd48,  1'b1}, // R2 engage again
        '{8'd8,  1'b0, 1'b0, 1'b1,  9'sd0,   8'd40, 1'b1, 8'd48,  1'b0}, // R8 rx off beats engage, no preload
        '{8'd4,  1'b1, 1'b1, 1'b0,  9'sd0,   8'd48, 1'b1, 8'd48,  1'b0}, // R4 stays high
        '{8'd2,  1'b1, 1'b0, 1'b1,  9'sd0,   8'd48, 1'b0, 8'd48,  1'b1}, // R2 engage
        '{8'd6,  1'b1, 1'b1, 1'b0,  9'sd0,   8'd48, 1'b0, 8'd48,  1'b0}, // R6 hold
        '{8'd8,  1'b0, 1'b1, 1'b0,  9'sd0,   8'd48, 1'b1, 8'd48,  1'b0}, // R8 rx off mid-packet
        '{8'd12, 1'b1, 1'b1, 1'b0,  9'sd255, 8'd48, 1'b1, 8'd255, 1'b0}, // R12 top rail
        '{8'd12, 1'b1, 1'b1, 1'b0,  9'sd1,   8'd48, 1'b1, 8'd255, 1'b0}, // R12 no wrap up
        '{8'd12, 1'b1, 1'b1, 1'b0, -9'sd256, 8'd48, 1'b1, 8'd0,   1'b0}, // R12 bottom rail
        '{8'd12, 1'b1, 1'b1, 1'b0, -9'sd1,   8'd48, 1'b1, 8'd0,   1'b0}, // R12 no wrap down
        '{8'd12, 1'b1, 1'b1, 1'b0,  9'sd7,   8'd48, 1'b1, 8'd7,   1'b0}  // R12 add from zero
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        for (int w = 0; w < 5000; w++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 gain_hi", int'(gain_hi), 1);
        chk("R1 acc_val", int'(acc_val), 0);
        chk("R1 drop_lock", int'(drop_lock), 0);
        chk("R1 pad_db", int'(pad_db), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            rx_en      = VECS[i].rx;
            agc_locked = VECS[i].lk;
            sat_det    = VECS[i].st;
            acc_delta  = VECS[i].dl;
            thr_cfg    = VECS[i].thr;
            @(negedge clk);
            chk($sformatf("R%0d v%0d gain_hi", VECS[i].tag, i), int'(gain_hi), int'(VECS[i].eg));
            chk($sformatf("R%0d v%0d acc_val", VECS[i].tag, i), int'(acc_val), int'(VECS[i].ea));
            chk($sformatf("R10 v%0d drop_lock", i), int'(drop_lock), int'(VECS[i].ed));
            chk($sformatf("R11 v%0d pad_db", i), int'(pad_db), VECS[i].eg ? 0 : 60);
        end

        // R11 pad_db follows pad_cfg while engaged
        rx_en = 1'b1; agc_locked = 1'b0; sat_det = 1'b1; acc_delta = '0; thr_cfg = 8'd48;
        @(negedge clk);
        sat_det = 1'b0; agc_locked = 1'b1;
        pad_cfg = 8'd20;
        #0.5;
        chk("R11 pad_db new cfg", int'(pad_db), 20);
        @(negedge clk);
        chk("R10 pulse one cycle", int'(drop_lock), 0);

        // R1 mid-run reset
        rst_n = 1'b0;
        #0.5;
        chk("R1 async gain_hi", int'(gain_hi), 1);
        chk("R1 async acc_val", int'(acc_val), 0);
        chk("R1 async pad_db", int'(pad_db), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset gain_hi", int'(gain_hi), 1);

        done = 1'b1;
        summary();
    end

endmodule